// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register holding the resolved directions of the most recent branches. It also keeps a table of small saturating counters. For each lookup, the history and some low bits of the fetch address are combined into a table index. The top bit of the selected counter is the prediction. A parameter chooses how the index is formed. Select mode places the history bits above the address bits. Share mode XORs the history into the address bits.

The prediction and the index it used come out in the same cycle as the lookup address, with no register in between. The pipeline keeps that index with the branch. When the branch resolves, the pipeline returns the index together with the real direction. Only that one counter moves, one step toward the real direction. The real direction is also shifted into the history. Because the stored index is used, an update lands on the right counter even if the history has moved on since the lookup.

Top module: `gcorr_predictor`

## Requirements
- R1: After a synchronous active-high reset, every counter holds 01 (weakly not taken) and the history is all zeros. A lookup then predicts not taken, and its index is just the address bits.
- R2: In select mode (the default), `pred_idx` is {history, fetch_pc[PC_BITS+1:2]}, with the history in the upper bits.
- R3: In share mode, `pred_idx` is fetch_pc[PC_BITS+1:2] XOR the history, with the history zero-extended on the left.
- R4: Address bits [1:0] have no effect on the index or on the prediction.
- R5: The prediction is the counter's top bit. Counter values 10 and 11 predict taken (`pred_taken`=1). Values 00 and 01 predict not taken.
- R6: A taken update adds one to the selected counter, and a not-taken update subtracts one. The counter saturates at 11 and at 00, so a strong value needs two opposite outcomes in a row to flip the prediction.
- R7: An update changes only the counter at `upd_idx`. Every other counter keeps its value.
- R8: Each update shifts its direction (1 = taken) into the history at the LSB, so the MSB holds the oldest outcome. Without an update, the history does not change.
- R9: If a lookup and an update select the same counter in the same cycle, the lookup returns the counter's value from before the update.
- R10: An update acts on the counter at the supplied `upd_idx`, whatever the current history is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_idx | input | IDX_W | Index returned from prediction time |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The assertions assume that whenever `upd_valid` is high, `upd_idx` and `upd_taken` are known values. They also assume that `upd_idx` addresses an entry that exists. In the bench, every update carries an index that a lookup produced earlier, or a constant inside the table's range. When no update is presented, the update inputs are held at zero. Because the lookup path is combinational, the bench changes inputs on the falling clock edge and samples the outputs shortly after. This means each result reflects the state committed at the previous rising edge.

// File: rtl/gcorr_pkg.sv
package gcorr_pkg;

    typedef enum logic {
        IDX_SELECT = 1'b0,
        IDX_SHARE  = 1'b1
    } idx_mode_e;

    // Table index width for a given mode and field widths.
    function automatic int idx_width(idx_mode_e mode, int hist_w, int pc_bits);
        if (mode == IDX_SELECT)
            return hist_w + pc_bits;
        else
            return (hist_w > pc_bits) ? hist_w : pc_bits;
    endfunction

    localparam int DEF_HIST_W  = 2;
    localparam int DEF_CTR_W   = 2;
    localparam int DEF_PC_BITS = 4;
    localparam int DEF_PC_W    = 32;

endpackage

// File: rtl/gcorr_history.sv
module gcorr_history #(
    parameter int HIST_W = gcorr_pkg::DEF_HIST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= shift_bit;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
            end
        end
    endgenerate

    assign hist = hist_q;

    // R8: history holds without an update
    p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));

    // R8: newest outcome lands at the LSB
    p_hist_newest_r8: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(shift_bit));

endmodule

// File: rtl/gcorr_index.sv
module gcorr_index
    import gcorr_pkg::*;
#(
    parameter idx_mode_e MODE    = IDX_SELECT,
    parameter int        HIST_W  = DEF_HIST_W,
    parameter int        PC_BITS = DEF_PC_BITS,
    parameter int        PC_W    = DEF_PC_W,
    localparam int       IDX_W   = idx_width(MODE, HIST_W, PC_BITS)
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic [PC_BITS-1:0] pc_field;
    assign pc_field = pc[PC_BITS+1:2];

    generate
        if (MODE == IDX_SELECT) begin : g_select
            assign idx = {hist, pc_field};
        end else begin : g_share
            assign idx = IDX_W'(pc_field) ^ IDX_W'(hist);
        end
    endgenerate

endmodule

// File: rtl/gcorr_table.sv
module gcorr_table #(
    parameter int  IDX_W = 6,
    parameter int  CTR_W = gcorr_pkg::DEF_CTR_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_MIN  = '0;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_nxt;

    assign wr_cur = ctr_q[wr_idx];

    always_comb begin
        wr_nxt = wr_cur;
        if (wr_taken && wr_cur != CTR_MAX)       wr_nxt = wr_cur + 1'b1;
        else if (!wr_taken && wr_cur != CTR_MIN) wr_nxt = wr_cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_nxt;
        end
    end

    // Read sees the committed value (pre-update on a same-cycle hit).
    assign rd_taken = ctr_q[rd_idx][CTR_W-1];

    // R6: saturation at the top
    p_sat_top_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX)
        |=> ctr_q[$past(wr_idx)] == CTR_MAX);

    // R6: saturation at the bottom
    p_sat_bottom_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_MIN)
        |=> ctr_q[$past(wr_idx)] == CTR_MIN);

    // R7: every unselected counter keeps its value
    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_keep
            p_other_kept_r7: assert property (@(posedge clk) disable iff (rst)
                (!wr_en || wr_idx != IDX_W'(e)) |=> $stable(ctr_q[e]));
        end
    endgenerate

endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor
    import gcorr_pkg::*;
#(
    parameter idx_mode_e MODE    = IDX_SELECT,
    parameter int        HIST_W  = DEF_HIST_W,
    parameter int        CTR_W   = DEF_CTR_W,
    parameter int        PC_BITS = DEF_PC_BITS,
    parameter int        PC_W    = DEF_PC_W,
    localparam int       IDX_W   = idx_width(MODE, HIST_W, PC_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_idx,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    logic [HIST_W-1:0] hist;

    gcorr_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (hist)
    );

    gcorr_index #(
        .MODE    (MODE),
        .HIST_W  (HIST_W),
        .PC_BITS (PC_BITS),
        .PC_W    (PC_W)
    ) u_index (
        .pc   (fetch_pc),
        .hist (hist),
        .idx  (pred_idx)
    );

    gcorr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    // R4: low address bits never move the index
    p_low_bits_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        ($stable(fetch_pc[PC_W-1:2]) && !$past(upd_valid)) |-> $stable(pred_idx));

    // Update inputs are known when valid
    p_upd_known: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !$isunknown({upd_idx, upd_taken}));

endmodule

// File: tb/gcorr_predictor_tb_top.sv
module gcorr_predictor_tb_top;
    import gcorr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // select-mode instance (index 6 bits)
    logic [31:0] pc_a = '0;
    logic        pt_a;
    logic [5:0]  pi_a;
    logic        uv_a = 1'b0;
    logic [5:0]  ui_a = '0;
    logic        ut_a = 1'b0;

    // share-mode instance (index 4 bits)
    logic [31:0] pc_b = '0;
    logic        pt_b;
    logic [3:0]  pi_b;
    logic        uv_b = 1'b0;
    logic [3:0]  ui_b = '0;
    logic        ut_b = 1'b0;

    gcorr_predictor #(.MODE(IDX_SELECT)) dut_i (
        .clk(clk), .rst(rst), .fetch_pc(pc_a), .pred_taken(pt_a), .pred_idx(pi_a),
        .upd_valid(uv_a), .upd_idx(ui_a), .upd_taken(ut_a));

    gcorr_predictor #(.MODE(IDX_SHARE)) dut_gs_i (
        .clk(clk), .rst(rst), .fetch_pc(pc_b), .pred_taken(pt_b), .pred_idx(pi_b),
        .upd_valid(uv_b), .upd_idx(ui_b), .upd_taken(ut_b));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [7:0] pc;
        logic       uv;
        logic [5:0] ui;
        logic       ut;
        logic [5:0] eidx;
        logic       epred;
    } vec_t;

    // select mode, single branch address 0x10 (address field 0100)
    localparam vec_t VEC [10] = '{
        '{8'h10, 1'b1, 6'h04, 1'b1, 6'h04, 1'b0},
        '{8'h10, 1'b1, 6'h14, 1'b1, 6'h14, 1'b0},
        '{8'h10, 1'b1, 6'h34, 1'b1, 6'h34, 1'b0},
        '{8'h10, 1'b1, 6'h34, 1'b1, 6'h34, 1'b1},
        '{8'h10, 1'b1, 6'h34, 1'b1, 6'h34, 1'b1},
        '{8'h10, 1'b1, 6'h34, 1'b0, 6'h34, 1'b1},
        '{8'h10, 1'b1, 6'h24, 1'b0, 6'h24, 1'b0},
        '{8'h10, 1'b1, 6'h04, 1'b0, 6'h04, 1'b1},
        '{8'h10, 1'b0, 6'h00, 1'b0, 6'h04, 1'b0},
        '{8'h13, 1'b0, 6'h00, 1'b0, 6'h04, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 2 ns later, commit at the next rise.
    task automatic step_a(input logic [31:0] pc, input logic uv, input logic [5:0] ui,
                          input logic ut, input logic [5:0] eidx, input logic epred,
                          input string tag, input bit chk);
        @(negedge clk);
        pc_a = pc; uv_a = uv; ui_a = ui; ut_a = ut;
        #2;
        if (chk) begin
            check({tag, " index"}, int'(pi_a), int'(eidx));
            check({tag, " prediction"}, int'(pt_a), int'(epred));
        end
        @(posedge clk);
    endtask

    task automatic step_b(input logic [31:0] pc, input logic uv, input logic [3:0] ui,
                          input logic ut, input logic [3:0] eidx, input logic epred,
                          input string tag);
        @(negedge clk);
        pc_b = pc; uv_b = uv; ui_b = ui; ut_b = ut;
        #2;
        check({tag, " index"}, int'(pi_b), int'(eidx));
        check({tag, " prediction"}, int'(pt_b), int'(epred));
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, index is the address field only
        step_a(32'h3C, 1'b0, 6'h00, 1'b0, 6'h0F, 1'b0, "R1 reset", 1'b1);
        step_b(32'h10, 1'b0, 4'h0, 1'b0, 4'h4, 1'b0, "R1 reset share");

        // R2 R5 R6 R8 R9: table walk; each row reads and updates the same entry
        foreach (VEC[k]) begin
            step_a({24'h0, VEC[k].pc}, VEC[k].uv, VEC[k].ui, VEC[k].ut,
                   VEC[k].eidx, VEC[k].epred,
                   (k == 9) ? "R4 low address bits" : "R2/R5/R6/R9 row", 1'b1);
        end

        // R10: updates hit the supplied index regardless of history
        step_a(32'h0, 1'b1, 6'h3F, 1'b1, 6'h00, 1'b0, "R10", 1'b0);
        step_a(32'h0, 1'b1, 6'h3F, 1'b1, 6'h00, 1'b0, "R10", 1'b0);
        step_a(32'h3C, 1'b0, 6'h00, 1'b0, 6'h3F, 1'b1, "R10 target", 1'b1);
        // R7: neighbour entry untouched
        step_a(32'h38, 1'b0, 6'h00, 1'b0, 6'h3E, 1'b0, "R7 neighbour", 1'b1);

        // R6: bottom saturation of entry 0x24 (currently 00)
        step_a(32'h0, 1'b1, 6'h24, 1'b0, 6'h00, 1'b0, "R6", 1'b0);
        step_a(32'h0, 1'b1, 6'h24, 1'b1, 6'h00, 1'b0, "R6", 1'b0);
        step_a(32'h0, 1'b1, 6'h00, 1'b0, 6'h00, 1'b0, "R6", 1'b0);
        step_a(32'h10, 1'b0, 6'h00, 1'b0, 6'h24, 1'b0, "R6 low saturation", 1'b1);
        // R8: no update -> history (10) unchanged
        step_a(32'h10, 1'b0, 6'h00, 1'b0, 6'h24, 1'b0, "R8 hold", 1'b1);

        // R3: share-mode indexing
        step_b(32'h10, 1'b1, 4'h4, 1'b1, 4'h4, 1'b0, "R3 share");
        step_b(32'h10, 1'b1, 4'h5, 1'b1, 4'h5, 1'b0, "R3 share hist 01");
        step_b(32'h10, 1'b0, 4'h0, 1'b0, 4'h7, 1'b0, "R3 share hist 11");
        step_b(32'h1C, 1'b0, 4'h0, 1'b0, 4'h4, 1'b1, "R3 share alias");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule